// File: doc/BRIEF.md
# Table-Driven Finite State Machine

This block is a finite state machine with no hand-written next-state or output gates. One lookup table does both jobs. The table address joins the primary inputs with the present state. Each word holds the outputs and the next state. On every clock edge a single register captures the selected word. The state part of that register feeds back into the address. A different machine is obtained by loading different words, not by changing logic.

A synchronous reset places the machine in a parameterised start state and clears the outputs. It also reloads every table word from a default image that a package function computes. A write port can rewrite any single word once per clock. With zero state bits the same structure acts as a registered lookup of a combinational function of the inputs.

Top module: `lut_fsm`

## Requirements
- R1: The table holds 2^(IN_W+ST_W) words of OUT_W+ST_W bits. In each word the next state sits in the low ST_W bits and the outputs sit in the bits above them.
- R2: The lookup address is {in_i, state_o}. The present state occupies the low ST_W address bits and the inputs the bits above.
- R3: On every clock edge out taken from reset, the register loads the selected word, so out_o shows the output field of the word addressed one cycle earlier.
- R4: state_o after each edge equals the next-state field of the word addressed in the cycle before.
- R5: A clock edge with rst high sets state_o to INIT_STATE (default 1) and out_o to 0. It also reloads word a with output field (a*5+3) mod 2^OUT_W and next-state field (st+in+1) mod 2^ST_W, where st is the low ST_W bits of a and in is the bits above.
- R6: A clock edge with wr_en high and rst low stores wr_data at wr_addr. A lookup in that same cycle still uses the old word. Lookups from the next cycle on use the new word.
- R7: A write leaves every word other than the one at wr_addr unchanged.
- R8: A write presented while rst is high has no effect. After reset the word holds its default image value.
- R9: With ST_W=0 the address is in_i alone, state_o is a constant 0 of one bit, and out_o is the word at in_i one cycle later. By default that word is (in*5+3) mod 2^OUT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_i | input | IN_W | Primary inputs, upper address bits |
| wr_en | input | 1 | Table word write strobe |
| wr_addr | input | IN_W+ST_W | Address of the word to rewrite |
| wr_data | input | OUT_W+ST_W | New word, {outputs, next state} |
| out_o | output | OUT_W | Registered outputs |
| state_o | output | max(ST_W,1) | Registered present state |

## Verification
A wrong table word or a misordered address is visible at out_o and state_o one edge after the bad lookup. Because the state feeds back, the error then propagates into every later lookup. Sweeping varied inputs through a walk of the machine against a bench copy of the table therefore exposes such a fault within a cycle of the first bad access. Write timing faults show up on the step that revisits the written address, either one step too early or one step too late. A separate zero-state instance sweeps all input codes.

// File: rtl/lut_fsm_pkg.sv
package lut_fsm_pkg;

  // Output field of the default image for table address a
  function automatic int unsigned dflt_out(int unsigned a, int unsigned out_w);
    return (a * 5 + 3) & ((32'd1 << out_w) - 32'd1);
  endfunction

  // Next-state field of the default image: state + input + 1, wrapped
  function automatic int unsigned dflt_next(int unsigned a, int unsigned st_w);
    int unsigned st;
    int unsigned iv;
    if (st_w == 0) return 0;
    st = a & ((32'd1 << st_w) - 32'd1);
    iv = a >> st_w;
    return (st + iv + 1) & ((32'd1 << st_w) - 32'd1);
  endfunction

  // Whole word: {outputs, next state}
  function automatic int unsigned dflt_word(int unsigned a, int unsigned out_w,
                                            int unsigned st_w);
    return (dflt_out(a, out_w) << st_w) | dflt_next(a, st_w);
  endfunction

endpackage

// File: rtl/lut_fsm_addr.sv
module lut_fsm_addr #(
  parameter int IN_W = 2,
  parameter int ST_W = 2,
  parameter int SW   = 2,
  parameter int AW   = 4
) (
  input  logic [IN_W-1:0] in_i,
  input  logic [SW-1:0]   st_i,
  output logic [AW-1:0]   addr_o
);
  generate
    if (ST_W == 0) begin : g_comb
      assign addr_o = in_i;
    end else begin : g_seq
      // state bits in the least significant positions
      assign addr_o = {in_i, st_i};
    end
  endgenerate
endmodule

// File: rtl/lut_fsm_table.sv
module lut_fsm_table
  import lut_fsm_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 5,
  parameter int OUT_W = 3,
  parameter int ST_W  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= DW'(dflt_word(i, OUT_W, ST_W));
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read is combinational; the register downstream samples it
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lut_fsm_reg.sv
module lut_fsm_reg #(
  parameter int OUT_W      = 3,
  parameter int ST_W       = 2,
  parameter int SW         = 2,
  parameter int DW         = 5,
  parameter int INIT_STATE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    word_i,
  output logic [OUT_W-1:0] out_q,
  output logic [SW-1:0]    state_q
);
  generate
    if (ST_W == 0) begin : g_comb
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= word_i[OUT_W-1:0];
      end
      assign state_q = '0;
    end else begin : g_seq
      always_ff @(posedge clk) begin
        if (rst) begin
          out_q   <= '0;
          state_q <= SW'(INIT_STATE);
        end else begin
          {out_q, state_q} <= word_i;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lut_fsm.sv
module lut_fsm #(
  parameter int IN_W       = 2,
  parameter int ST_W       = 2,
  parameter int OUT_W      = 3,
  parameter int INIT_STATE = 1,
  localparam int AW = IN_W + ST_W,
  localparam int DW = OUT_W + ST_W,
  localparam int SW = (ST_W > 0) ? ST_W : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [OUT_W-1:0] out_o,
  output logic [SW-1:0]    state_o
);
  // Named internal events for the checker
  logic [AW-1:0] look_addr;
  logic [DW-1:0] look_word;

  lut_fsm_addr #(.IN_W(IN_W), .ST_W(ST_W), .SW(SW), .AW(AW)) u_addr (
    .in_i   (in_i),
    .st_i   (state_o),
    .addr_o (look_addr)
  );

  lut_fsm_table #(.AW(AW), .DW(DW), .OUT_W(OUT_W), .ST_W(ST_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (look_addr),
    .rd_data (look_word)
  );

  lut_fsm_reg #(.OUT_W(OUT_W), .ST_W(ST_W), .SW(SW), .DW(DW),
                .INIT_STATE(INIT_STATE)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .word_i  (look_word),
    .out_q   (out_o),
    .state_q (state_o)
  );
endmodule

// File: rtl/lut_fsm_chk.sv
module lut_fsm_chk #(
  parameter int IN_W       = 2,
  parameter int ST_W       = 2,
  parameter int OUT_W      = 3,
  parameter int INIT_STATE = 1,
  parameter int AW = IN_W + ST_W,
  parameter int DW = OUT_W + ST_W,
  parameter int SW = (ST_W > 0) ? ST_W : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [OUT_W-1:0] out_o,
  input logic [SW-1:0]    state_o,
  input logic [AW-1:0]    look_addr,
  input logic [DW-1:0]    look_word
);
  localparam logic [SW-1:0] RST_ST = (ST_W > 0) ? SW'(INIT_STATE) : '0;

  // R5
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_o == '0 && state_o == RST_ST));

  // R3
  out_from_word_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_o == $past(look_word[DW-1:ST_W]));

  // R6
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (look_addr != $past(wr_addr) || look_word == $past(wr_data)));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (look_addr != $past(look_addr) || $stable(look_word)));

  generate
    if (ST_W > 0) begin : g_fb
      // R4
      state_feedback_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_o == $past(look_word[ST_W-1:0]));
    end else begin : g_nofb
      // R9
      state_zero_chk: assert property (@(posedge clk) disable iff (rst)
        state_o == '0);
    end
  endgenerate
endmodule

bind lut_fsm lut_fsm_chk #(
  .IN_W(IN_W), .ST_W(ST_W), .OUT_W(OUT_W), .INIT_STATE(INIT_STATE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .out_o     (out_o),
  .state_o   (state_o),
  .look_addr (look_addr),
  .look_word (look_word)
);

// File: tb/lut_fsm_tb_top.sv
module lut_fsm_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] in_v = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic [2:0] out_o;
  logic [1:0] state_o;

  logic [2:0] c_in = '0;
  logic [3:0] c_out;
  logic [0:0] c_state;

  int total = 0;
  int bad   = 0;
  int mdl [DEPTH];
  int m_st  = 1;
  int m_out = 0;

  always #(CLK_P / 2) clk = ~clk;

  lut_fsm dut_i (
    .clk(clk), .rst(rst), .in_i(in_v), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_o(out_o), .state_o(state_o)
  );

  lut_fsm #(.IN_W(3), .ST_W(0), .OUT_W(4), .INIT_STATE(0)) dut_comb_i (
    .clk(clk), .rst(rst), .in_i(c_in), .wr_en(1'b0), .wr_addr(3'd0),
    .wr_data(4'd0), .out_o(c_out), .state_o(c_state)
  );

  // Default image restated: out bits (a*5+3)&7 above, next (st+in+1)&3 below
  function automatic int img(int a);
    return ((((a * 5) + 3) % 8) * 4) + (((a % 4) + (a / 4) + 1) % 4);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit with_wr);
    rst = 1'b1;
    wr_en = with_wr; wr_addr = 4'd5; wr_data = 5'd31;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int a = 0; a < DEPTH; a++) mdl[a] = img(a);
    m_st = 1; m_out = 0;
  endtask

  // One clock step; model applies read-before-write
  task automatic step(int iv, bit we, int wa, int wd);
    int w;
    in_v = 2'(iv); wr_en = we; wr_addr = 4'(wa); wr_data = 5'(wd);
    @(negedge clk);
    w = mdl[iv * 4 + m_st];
    m_out = w / 4;
    m_st  = w % 4;
    if (we) mdl[wa] = wd;
    wr_en = 1'b0;
  endtask

  task automatic chk_step(string tag);
    chk(tag, int'(out_o), m_out);
    chk(tag, int'(state_o), m_st);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R5: reset values
    chk("R5 out", int'(out_o), 0);
    chk("R5 state", int'(state_o), 1);

    // R2 R3 R4 R5: walk the default image with varied input patterns
    for (int i = 0; i < 48; i++) begin
      step((i * 7 + 3 + i / 5) % 4, 1'b0, 0, 0);
      chk_step("R2 R3 R4 walk");
    end

    // R6: write to the word being looked up this cycle; old word is used
    begin
      int a;
      a = 2 * 4 + m_st;
      step(2, 1'b1, a, 5'b10110);
      chk_step("R6 same-cycle");
    end
    // R6: write ahead of use, then visit it
    for (int i = 0; i < 8; i++) begin
      int ns;
      int tgt;
      ns  = mdl[1 * 4 + m_st] % 4;
      tgt = 3 * 4 + ns;
      step(1, 1'b1, tgt, (i * 9 + 5) % 32);
      chk_step("R6 write step");
      step(3, 1'b0, 0, 0);
      chk_step("R6 new word");
    end

    // R7: words not written stay intact
    for (int i = 0; i < 24; i++) begin
      step(i % 3, 1'b0, 0, 0);
      chk_step("R7 neighbours");
    end

    // R8: write during reset ignored; address 5 = {in 1, state 1}
    do_reset(1'b1);
    step(1, 1'b0, 0, 0);
    chk("R8 out", int'(out_o), img(5) / 4);
    chk("R8 state", int'(state_o), img(5) % 4);

    // R1: reprogram all 16 words, fields {out[4:2], next[1:0]}
    for (int a = 0; a < DEPTH; a++) begin
      in_v = 2'(a % 4); wr_en = 1'b1; wr_addr = 4'(a);
      wr_data = 5'((a * 11 + 7) % 32);
      @(negedge clk);
      begin
        int w;
        w = mdl[(a % 4) * 4 + m_st];
        m_out = w / 4; m_st = w % 4;
      end
      mdl[a] = (a * 11 + 7) % 32;
    end
    wr_en = 1'b0;
    chk_step("R1 during load");
    for (int i = 0; i < 40; i++) begin
      step((i * 5 + 1) % 4, 1'b0, 0, 0);
      chk_step("R1 R2 reprogrammed");
    end

    // R9: zero-state instance, all input codes
    for (int i = 0; i < 8; i++) begin
      c_in = 3'(i);
      @(negedge clk);
      chk("R9 out", int'(c_out), (i * 5 + 3) % 16);
      chk("R9 state", int'(c_state), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule